// File: doc/BRIEF.md
# Flag Offset Register Load Sequencer

This block holds the two offsets that a FIFO's almost-empty and almost-full flag logic compares against, and it decides what the FIFO's write-enable and read-enable inputs mean. While the configuration select `cfg_sel` is low, write enable and read enable pass through as ordinary FIFO write and read strobes. While `cfg_sel` is high, they are taken away from the FIFO and used to access the offset registers. Write enable loads the low bits of the input data bus into one offset register per write-clock edge. Read enable copies one offset register onto the readback bus per read-clock edge.

Each clock domain has its own two-state sequencer, and each one selects which register the next access targets. The write sequencer has the states `WR_AT_EMPTY` and `WR_AT_FULL`. A load write in `WR_AT_EMPTY` updates the almost-empty offset and moves to `WR_AT_FULL`. A load write in `WR_AT_FULL` updates the almost-full offset and moves back to `WR_AT_EMPTY`. In every other case the state holds. The read sequencer has the states `RD_AT_EMPTY` and `RD_AT_FULL` and moves the same way on each load read. The two sequencers never influence each other.

Software can load one register, drop `cfg_sel` to run traffic, and later raise `cfg_sel` again. The sequence then carries on from the register where it stopped. An asynchronous active-low reset restores the default offsets, clears the readback register and puts both sequencers back at the almost-empty register.

Top module: `ofs_load_seq`

## Requirements
- R1: After reset, `ae_ofs` equals DEF_AE (127), `af_ofs` equals DEF_AF (127), `rb_data` is 0, and both sequencers are in the almost-empty state.
- R2: With `cfg_sel`=1 and `wr_en`=1, successive `wclk` edges write `din[OFS_W-1:0]` to `ae_ofs`, then to `af_ofs`, then to `ae_ofs` again. Each edge updates exactly one register.
- R3: With `cfg_sel`=1 and `wr_en`=0, a `wclk` edge changes neither offset and does not advance the write sequencer.
- R4: With `cfg_sel`=0, `fifo_wr` equals `wr_en` and neither offset changes. With `cfg_sel`=1, `fifo_wr` is 0.
- R5: When `cfg_sel` falls after a single load write, the next load write targets the other register (the write sequence resumes).
- R6: With `cfg_sel`=1 and `rd_en`=1, successive `rclk` edges place `ae_ofs`, then `af_ofs`, then `ae_ofs` on `rb_data`. The read sequence position is independent of the write sequence position.
- R7: With `cfg_sel`=0, `fifo_rd` equals `rd_en`. With `cfg_sel`=1, `fifo_rd` is 0. Without a load read, `rb_data` and the read sequencer hold.
- R8: Data bits at and above bit OFS_W (10) of `din` have no effect on the stored offsets.
- R9: A load write and a load read in the same cycle are outside the contract. The user must never assert `cfg_sel`, `wr_en` and `rd_en` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | 1: enables access the offset registers; 0: normal FIFO operation |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| din | input | DATA_W (18) | FIFO input data; the low OFS_W bits carry offsets |
| ae_ofs | output | OFS_W (10) | Almost-empty offset |
| af_ofs | output | OFS_W (10) | Almost-full offset |
| rb_data | output | OFS_W (10) | Offset readback register |
| fifo_wr | output | 1 | Write strobe passed to FIFO storage |
| fifo_rd | output | 1 | Read strobe passed to FIFO storage |

## Verification
`fifo_wr` and `fifo_rd` are combinational, so the bench checks them 1 ns after it drives the inputs, in the same cycle and before any clock edge. `ae_ofs`, `af_ofs` and `rb_data` each pass through one register, so they are due one edge after the stimulus. The bench drives each vector on a falling edge, lets exactly one rising edge pass, and samples these outputs on the next falling edge. The sequencer positions have no port of their own. The bench reads them out through the next load write or load read, whose target register shows where the sequencer stood.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    // Write-side sequencer position: which offset the next load write hits.
    typedef enum logic {
        WR_AT_EMPTY = 1'b0,
        WR_AT_FULL  = 1'b1
    } wr_seq_e;

    // Read-side sequencer position: which offset the next load read returns.
    typedef enum logic {
        RD_AT_EMPTY = 1'b0,
        RD_AT_FULL  = 1'b1
    } rd_seq_e;

endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
    import ofs_pkg::*;
#(
    parameter int unsigned OFS_W  = 10,
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DEF_AE = 127,
    parameter int unsigned DEF_AF = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic              fifo_wr
);

    localparam logic [OFS_W-1:0] AE_INIT = OFS_W'(DEF_AE);
    localparam logic [OFS_W-1:0] AF_INIT = OFS_W'(DEF_AF);

    wr_seq_e          state_q, state_d;
    logic             load_wr;
    logic [OFS_W-1:0] ofs_field;

    assign load_wr   = cfg_sel && wr_en;
    assign ofs_field = din[OFS_W-1:0];
    assign fifo_wr   = wr_en && !cfg_sel;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_AT_EMPTY: if (load_wr) state_d = WR_AT_FULL;
            WR_AT_FULL:  if (load_wr) state_d = WR_AT_EMPTY;
            default:     state_d = WR_AT_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_AT_EMPTY;
        else        state_q <= state_d;
    end

    // Output registers: the offsets.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= AE_INIT;
            af_ofs <= AF_INIT;
        end else if (load_wr) begin
            unique case (state_q)
                WR_AT_EMPTY: ae_ofs <= ofs_field;
                WR_AT_FULL:  af_ofs <= ofs_field;
                default:     ae_ofs <= ofs_field;
            endcase
        end
    end

endmodule

// File: rtl/ofs_rb_mux.sv
module ofs_rb_mux
    import ofs_pkg::*;
#(
    parameter int unsigned OFS_W = 10
) (
    input  rd_seq_e          sel,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] mux_out
);

    always_comb begin
        unique case (sel)
            RD_AT_EMPTY: mux_out = ae_ofs;
            RD_AT_FULL:  mux_out = af_ofs;
            default:     mux_out = ae_ofs;
        endcase
    end

endmodule

// File: rtl/ofs_rd_seq.sv
module ofs_rd_seq
    import ofs_pkg::*;
#(
    parameter int unsigned OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sel,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] rb_data,
    output logic             fifo_rd
);

    rd_seq_e          state_q, state_d;
    logic             load_rd;
    logic [OFS_W-1:0] sel_ofs;

    assign load_rd = cfg_sel && rd_en;
    assign fifo_rd = rd_en && !cfg_sel;

    ofs_rb_mux #(.OFS_W(OFS_W)) u_mux (
        .sel     (state_q),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .mux_out (sel_ofs)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_AT_EMPTY: if (load_rd) state_d = RD_AT_FULL;
            RD_AT_FULL:  if (load_rd) state_d = RD_AT_EMPTY;
            default:     state_d = RD_AT_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_AT_EMPTY;
        else        state_q <= state_d;
    end

    // Output register: the readback value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rb_data <= '0;
        else if (load_rd) rb_data <= sel_ofs;
    end

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq #(
    parameter int unsigned OFS_W  = 10,
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DEF_AE = 127,
    parameter int unsigned DEF_AF = 127
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic [OFS_W-1:0]  rb_data,
    output logic              fifo_wr,
    output logic              fifo_rd
);

    ofs_wr_seq #(
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W),
        .DEF_AE (DEF_AE),
        .DEF_AF (DEF_AF)
    ) u_wr (
        .clk     (wclk),
        .rst_n   (rst_n),
        .cfg_sel (cfg_sel),
        .wr_en   (wr_en),
        .din     (din),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .fifo_wr (fifo_wr)
    );

    ofs_rd_seq #(
        .OFS_W (OFS_W)
    ) u_rd (
        .clk     (rclk),
        .rst_n   (rst_n),
        .cfg_sel (cfg_sel),
        .rd_en   (rd_en),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .rb_data (rb_data),
        .fifo_rd (fifo_rd)
    );

endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk #(
    parameter int unsigned OFS_W = 10
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             cfg_sel,
    input logic             wr_en,
    input logic             rd_en,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs,
    input logic [OFS_W-1:0] rb_data,
    input logic             fifo_wr,
    input logic             fifo_rd
);

    // A load write touches at most one of the two offsets.
    p_one_target_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (cfg_sel && wr_en) |=> ($stable(ae_ofs) || $stable(af_ofs)));

    // No load write: both offsets hold.
    p_offsets_hold_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        !(cfg_sel && wr_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

    // Load mode never reaches FIFO storage.
    p_no_fifo_wr_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        cfg_sel |-> !fifo_wr);

    p_no_fifo_rd_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        cfg_sel |-> !fifo_rd);

    // A load read returns one of the two offsets.
    p_rb_source_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (cfg_sel && rd_en) |=> (rb_data == $past(ae_ofs) || rb_data == $past(af_ofs)));

    // Without a load read the readback register holds.
    p_rb_hold_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        !(cfg_sel && rd_en) |=> $stable(rb_data));

endmodule

bind ofs_load_seq ofs_load_seq_chk #(.OFS_W(OFS_W)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .rst_n   (rst_n),
    .cfg_sel (cfg_sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .ae_ofs  (ae_ofs),
    .af_ofs  (af_ofs),
    .rb_data (rb_data),
    .fifo_wr (fifo_wr),
    .fifo_rd (fifo_rd)
);

// File: tb/sim_ofs_load_seq.sv
`timescale 1ns/1ps
module sim_ofs_load_seq;

    localparam int OFS_W  = 10;
    localparam int DATA_W = 18;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_sel, wr_en, rd_en;
    logic [DATA_W-1:0] din;
    logic [OFS_W-1:0]  ae_ofs, af_ofs, rb_data;
    logic              fifo_wr, fifo_rd;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ofs_load_seq #(.OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_AE(127), .DEF_AF(127)) u0 (
        .wclk (clk), .rclk (clk), .rst_n (rst_n),
        .cfg_sel (cfg_sel), .wr_en (wr_en), .rd_en (rd_en), .din (din),
        .ae_ofs (ae_ofs), .af_ofs (af_ofs), .rb_data (rb_data),
        .fifo_wr (fifo_wr), .fifo_rd (fifo_rd)
    );

    typedef struct packed {
        logic              cfg;
        logic              wr;
        logic              rd;
        logic [DATA_W-1:0] d;
        logic [OFS_W-1:0]  ae;
        logic [OFS_W-1:0]  af;
        logic [OFS_W-1:0]  rb;
        logic              fwr;
        logic              frd;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 18'h30005, 10'd5,    10'd127, 10'd0,    1'b0, 1'b0, 4'd8}, // R2 R8 first load -> empty
        '{1'b1, 1'b1, 1'b0, 18'h00200, 10'd5,    10'd512, 10'd0,    1'b0, 1'b0, 4'd2}, // R2 second load -> full
        '{1'b1, 1'b0, 1'b0, 18'h003FF, 10'd5,    10'd512, 10'd0,    1'b0, 1'b0, 4'd3}, // R3 idle in load mode
        '{1'b1, 1'b1, 1'b0, 18'h00011, 10'd17,   10'd512, 10'd0,    1'b0, 1'b0, 4'd2}, // R2 third load wraps to empty
        '{1'b0, 1'b1, 1'b0, 18'h002AA, 10'd17,   10'd512, 10'd0,    1'b1, 1'b0, 4'd4}, // R4 normal write passes through
        '{1'b1, 1'b1, 1'b0, 18'h000C8, 10'd17,   10'd200, 10'd0,    1'b0, 1'b0, 4'd5}, // R5 resumes at full
        '{1'b1, 1'b0, 1'b1, 18'h00000, 10'd17,   10'd200, 10'd17,   1'b0, 1'b0, 4'd6}, // R6 readback empty first
        '{1'b0, 1'b0, 1'b1, 18'h00000, 10'd17,   10'd200, 10'd17,   1'b0, 1'b1, 4'd7}, // R7 normal read, rb holds
        '{1'b1, 1'b0, 1'b1, 18'h00000, 10'd17,   10'd200, 10'd200,  1'b0, 1'b0, 4'd6}, // R6 readback full
        '{1'b1, 1'b0, 1'b1, 18'h00000, 10'd17,   10'd200, 10'd17,   1'b0, 1'b0, 4'd6}, // R6 readback wraps
        '{1'b1, 1'b0, 1'b0, 18'h00000, 10'd17,   10'd200, 10'd17,   1'b0, 1'b0, 4'd7}, // R7 no read, rb holds
        '{1'b1, 1'b1, 1'b0, 18'h3FFFF, 10'd1023, 10'd200, 10'd17,   1'b0, 1'b0, 4'd8}, // R8 all ones -> empty
        '{1'b1, 1'b0, 1'b1, 18'h00000, 10'd1023, 10'd200, 10'd200,  1'b0, 1'b0, 4'd6}  // R6 read pointer independent
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic w, input logic r, input logic [DATA_W-1:0] d);
        cfg_sel = c; wr_en = w; rd_en = r; din = d;
    endtask

    // R9 usage monitor: offset read and write in the same cycle.
    always @(posedge clk) begin
        if (rst_n && cfg_sel && wr_en && rd_en) begin
            errors++;
            checks++;
            $display("FAIL R9 simultaneous offset read and write: actual=1 expected=0");
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        drive(1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ae_ofs", int'(ae_ofs), 127);
        chk("R1", "af_ofs", int'(af_ofs), 127);
        chk("R1", "rb_data", int'(rb_data), 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            drive(VECS[i].cfg, VECS[i].wr, VECS[i].rd, VECS[i].d);
            #1;
            chk(tag, "fifo_wr", int'(fifo_wr), int'(VECS[i].fwr));
            chk(tag, "fifo_rd", int'(fifo_rd), int'(VECS[i].frd));
            @(negedge clk);
            chk(tag, "ae_ofs", int'(ae_ofs), int'(VECS[i].ae));
            chk(tag, "af_ofs", int'(af_ofs), int'(VECS[i].af));
            chk(tag, "rb_data", int'(rb_data), int'(VECS[i].rb));
        end

        // Move the read sequencer to full, then reset mid-sequence (R1).
        drive(1'b1, 1'b0, 1'b1, '0);
        @(negedge clk);
        chk("R6", "rb_data", int'(rb_data), 1023);
        drive(1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ae_ofs after reset", int'(ae_ofs), 127);
        chk("R1", "af_ofs after reset", int'(af_ofs), 127);
        chk("R1", "rb_data after reset", int'(rb_data), 0);
        // R1: write sequencer back at empty (was at full).
        drive(1'b1, 1'b1, 1'b0, 18'd7);
        @(negedge clk);
        chk("R1", "write seq at empty", int'(ae_ofs), 7);
        chk("R1", "af_ofs untouched", int'(af_ofs), 127);
        // R1: read sequencer back at empty (was at full).
        drive(1'b1, 1'b0, 1'b1, '0);
        @(negedge clk);
        chk("R1", "read seq at empty", int'(rb_data), 7);
        drive(1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule